// File: doc/BRIEF.md
# Repeated String Transfer Engine

This block carries out string-style block transfers on its own. A single start command chooses one of three operations: copy elements from a source index to a destination index, fill the destination with the accumulator, or read the source into the accumulator. Each element is one, two or four bytes wide. A direction input chooses whether the two indices rise or fall, and a repeat flag lets a count register set how many elements are processed.

The engine keeps private copies of the source index, the destination index, the count and the accumulator. It walks through the elements by issuing requests on one memory port. The request channel is valid/ready. While `mem_req_valid_o` is high and `mem_req_ready_i` is low, the engine holds the address, segment, size, write flag and write data unchanged. A request counts as accepted on a clock edge where both are high. A write needs nothing after it is accepted. An accepted read is answered later on a response channel, which is also valid/ready. The engine raises `mem_rsp_ready_o` only while it waits for read data, and it takes the data on the edge where `mem_rsp_valid_i` and `mem_rsp_ready_o` are both high. The memory side may stall either channel for any number of cycles.

When the operation ends, `done_o` pulses for one cycle. At that point `si_o`, `di_o`, `cx_o` and `acc_o` carry the final values, and they keep them until the next start.

Top module: `strx_engine`

## Requirements
- R1: Reads use segment select 0 (data segment) with the source index as address. Writes use segment select 1 (extra segment) with the destination index as address.
- R2: After each element, an index that is advanced moves by 1, 2 or 4 for size codes 0, 1 and 2 (size code 3 acts as 4). It moves up when direction is 0 and down when direction is 1, wrapping modulo 2^ADDR_W.
- R3: With repeat set and a non-zero count N, exactly N elements are processed, the count drops by one per element, and `cx_o` is 0 at done.
- R4: With repeat set and a count of 0, no request is issued and `done_o` is high in the cycle after the start is taken.
- R5: With repeat clear, exactly one element is processed and `cx_o` keeps the start count.
- R6: A load (op code 2; code 3 behaves the same) issues only reads and advances only the source index. It replaces the low element-sized bytes of the accumulator with the low element-sized bytes of the last read and keeps the upper accumulator bytes.
- R7: A store (op code 1) issues only writes and advances only the destination index. The write data is the accumulator's low element-sized bytes with the upper bytes zero.
- R8: A move (op code 0) issues the read of each element before its write. The write data is the read data's low element-sized bytes with the upper bytes zero. Both indices advance.
- R9: While a request is stalled, valid stays high and its address, write flag and write data do not change.
- R10: A start asserted while `busy_o` is high is ignored and does not disturb the running operation.
- R11: `done_o` lasts exactly one cycle, and the result outputs hold their values afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start command, taken when idle |
| op_i | input | 2 | 0 move, 1 store, 2 load |
| size_i | input | 2 | 0 byte, 1 word, 2 doubleword |
| rep_i | input | 1 | Repeat under control of the count |
| dir_i | input | 1 | 0 ascending, 1 descending |
| si_i | input | ADDR_W | Starting source index |
| di_i | input | ADDR_W | Starting destination index |
| cx_i | input | CNT_W | Starting count |
| acc_i | input | DATA_W | Starting accumulator |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| si_o | output | ADDR_W | Current/final source index |
| di_o | output | ADDR_W | Current/final destination index |
| cx_o | output | CNT_W | Current/final count |
| acc_o | output | DATA_W | Current/final accumulator |
| mem_req_valid_o | output | 1 | Request valid |
| mem_req_ready_i | input | 1 | Request ready |
| mem_req_we_o | output | 1 | 1 write, 0 read |
| mem_req_seg_o | output | 1 | 0 data segment, 1 extra segment |
| mem_req_size_o | output | 2 | Element size code |
| mem_req_addr_o | output | ADDR_W | Element address (lowest byte) |
| mem_req_wdata_o | output | DATA_W | Write data, little-endian lanes |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_ready_o | output | 1 | Engine waits for read data |
| mem_rsp_data_i | input | DATA_W | Read data, little-endian lanes |

## Verification
The bench builds the engine with ADDR_W=8, DATA_W=32 and CNT_W=8. With an 8-bit index, repeated runs cross the top and bottom of the address space in both directions, so index wrap is reached without long runs. The short count width keeps random repeat lengths small, so a mix of zero, single and multi-element runs fits in a short test. The memory model fills unused read lanes with random bytes and stalls both channels at random, which exercises lane masking and request holding.

// File: rtl/strx_pkg.sv
package strx_pkg;

  typedef enum logic [1:0] {
    OP_MOVE  = 2'd0,
    OP_STORE = 2'd1,
    OP_LOAD  = 2'd2,
    OP_LOAD2 = 2'd3
  } strx_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_FINISH
  } strx_state_e;

  // Bytes covered by one element for a size code.
  function automatic int unsigned elem_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/strx_stepper.sv
module strx_stepper #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] idx_i,
  input  logic [1:0]        size_i,
  input  logic              dir_i,
  output logic [ADDR_W-1:0] idx_o
);
  logic [ADDR_W-1:0] delta;

  always_comb begin
    delta = '0;
    case (size_i)
      2'd0:    delta[0] = 1'b1;
      2'd1:    delta[1] = 1'b1;
      default: delta[2] = 1'b1;
    endcase
    idx_o = dir_i ? (idx_i - delta) : (idx_i + delta);
  end
endmodule

// File: rtl/strx_index_reg.sv
module strx_index_reg #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              adv_i,
  input  logic [1:0]        size_i,
  input  logic              dir_i,
  output logic [ADDR_W-1:0] idx_o
);
  logic [ADDR_W-1:0] nxt;

  strx_stepper #(.ADDR_W(ADDR_W)) u_step (
    .idx_i (idx_o),
    .size_i(size_i),
    .dir_i (dir_i),
    .idx_o (nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_o <= '0;
    else if (load_i) idx_o <= load_val_i;
    else if (adv_i)  idx_o <= nxt;
  end
endmodule

// File: rtl/strx_lane_merge.sv
module strx_lane_merge #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] base_i,
  input  logic [DATA_W-1:0] new_i,
  input  logic [1:0]        size_i,
  output logic [DATA_W-1:0] out_o
);
  import strx_pkg::*;
  localparam int LANES = DATA_W / 8;

  int unsigned      nb;
  logic [LANES-1:0] take;

  always_comb nb = elem_bytes(size_i);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign take[g]          = (nb > 32'(g));
    assign out_o[g*8 +: 8]  = take[g] ? new_i[g*8 +: 8] : base_i[g*8 +: 8];
  end
endmodule

// File: rtl/strx_fsm.sv
module strx_fsm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_fire_i,
  input  logic [1:0] op_i,
  input  logic       rep_i,
  input  logic       cx_zero_i,
  input  logic       req_ready_i,
  input  logic       rsp_valid_i,
  input  logic       cnt_last_i,
  output logic       req_valid_o,
  output logic       req_we_o,
  output logic       rsp_ready_o,
  output logic       rd_fire_o,
  output logic       elem_done_o,
  output logic       done_o,
  output logic       busy_o,
  output logic [1:0] op_o,
  output logic       rep_o
);
  import strx_pkg::*;

  strx_state_e state_q, state_d;
  logic [1:0]  op_q;
  logic        rep_q;
  logic        more;

  assign op_o  = op_q;
  assign rep_o = rep_q;
  assign more  = rep_q && !cnt_last_i;

  always_comb begin
    state_d     = state_q;
    req_valid_o = 1'b0;
    req_we_o    = 1'b0;
    rsp_ready_o = 1'b0;
    rd_fire_o   = 1'b0;
    elem_done_o = 1'b0;
    done_o      = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_fire_i) begin
          if (rep_i && cx_zero_i)  state_d = ST_FINISH;
          else if (op_i == OP_STORE) state_d = ST_WR_REQ;
          else                       state_d = ST_RD_REQ;
        end
      end
      ST_RD_REQ: begin
        req_valid_o = 1'b1;
        if (req_ready_i) state_d = ST_RD_WAIT;
      end
      ST_RD_WAIT: begin
        rsp_ready_o = 1'b1;
        if (rsp_valid_i) begin
          rd_fire_o = 1'b1;
          if (op_q == OP_MOVE) begin
            state_d = ST_WR_REQ;
          end else begin
            elem_done_o = 1'b1;
            state_d     = more ? ST_RD_REQ : ST_FINISH;
          end
        end
      end
      ST_WR_REQ: begin
        req_valid_o = 1'b1;
        req_we_o    = 1'b1;
        if (req_ready_i) begin
          elem_done_o = 1'b1;
          if (!more)                 state_d = ST_FINISH;
          else if (op_q == OP_MOVE)  state_d = ST_RD_REQ;
          else                       state_d = ST_WR_REQ;
        end
      end
      ST_FINISH: begin
        done_o  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign busy_o = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= 2'd0;
      rep_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_fire_i) begin
        op_q  <= op_i;
        rep_q <= rep_i;
      end
    end
  end
endmodule

// File: rtl/strx_engine.sv
module strx_engine #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic              rep_i,
  input  logic              dir_i,
  input  logic [ADDR_W-1:0] si_i,
  input  logic [ADDR_W-1:0] di_i,
  input  logic [CNT_W-1:0]  cx_i,
  input  logic [DATA_W-1:0] acc_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] si_o,
  output logic [ADDR_W-1:0] di_o,
  output logic [CNT_W-1:0]  cx_o,
  output logic [DATA_W-1:0] acc_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic              mem_req_we_o,
  output logic              mem_req_seg_o,
  output logic [1:0]        mem_req_size_o,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  output logic [DATA_W-1:0] mem_req_wdata_o,
  input  logic              mem_rsp_valid_i,
  output logic              mem_rsp_ready_o,
  input  logic [DATA_W-1:0] mem_rsp_data_i
);
  import strx_pkg::*;

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic              start_fire;
  logic              rd_fire, elem_done;
  logic [1:0]        op_q;
  logic              rep_q;
  logic [1:0]        size_q;
  logic              dir_q;
  logic [CNT_W-1:0]  cx_q;
  logic [DATA_W-1:0] acc_q, rdata_q;
  logic [DATA_W-1:0] rd_masked, acc_merged, acc_masked;
  logic              adv_src, adv_dst;

  assign start_fire = start_i && !busy_o;

  strx_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_fire_i(start_fire),
    .op_i        (op_i),
    .rep_i       (rep_i),
    .cx_zero_i   (cx_i == '0),
    .req_ready_i (mem_req_ready_i),
    .rsp_valid_i (mem_rsp_valid_i),
    .cnt_last_i  (cx_q == CNT_ONE),
    .req_valid_o (mem_req_valid_o),
    .req_we_o    (mem_req_we_o),
    .rsp_ready_o (mem_rsp_ready_o),
    .rd_fire_o   (rd_fire),
    .elem_done_o (elem_done),
    .done_o      (done_o),
    .busy_o      (busy_o),
    .op_o        (op_q),
    .rep_o       (rep_q)
  );

  assign adv_src = elem_done && (op_q != OP_STORE);
  assign adv_dst = elem_done && (op_q == OP_MOVE || op_q == OP_STORE);

  // Source and destination index registers share one structure.
  for (genvar k = 0; k < 2; k++) begin : g_idx
    logic              ld_adv;
    logic [ADDR_W-1:0] ld_val;
    logic [ADDR_W-1:0] q;
    assign ld_adv = (k == 0) ? adv_src : adv_dst;
    assign ld_val = (k == 0) ? si_i : di_i;
    strx_index_reg #(.ADDR_W(ADDR_W)) u_idx (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (start_fire),
      .load_val_i(ld_val),
      .adv_i     (ld_adv),
      .size_i    (size_q),
      .dir_i     (dir_q),
      .idx_o     (q)
    );
  end

  assign si_o = g_idx[0].q;
  assign di_o = g_idx[1].q;

  strx_lane_merge #(.DATA_W(DATA_W)) u_rd_mask (
    .base_i(DATA_W'(0)),
    .new_i (mem_rsp_data_i),
    .size_i(size_q),
    .out_o (rd_masked)
  );

  strx_lane_merge #(.DATA_W(DATA_W)) u_acc_merge (
    .base_i(acc_q),
    .new_i (mem_rsp_data_i),
    .size_i(size_q),
    .out_o (acc_merged)
  );

  strx_lane_merge #(.DATA_W(DATA_W)) u_acc_mask (
    .base_i(DATA_W'(0)),
    .new_i (acc_q),
    .size_i(size_q),
    .out_o (acc_masked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q  <= 2'd0;
      dir_q   <= 1'b0;
      cx_q    <= '0;
      acc_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (start_fire) begin
        size_q <= size_i;
        dir_q  <= dir_i;
        cx_q   <= cx_i;
        acc_q  <= acc_i;
      end else begin
        if (elem_done && rep_q) cx_q <= cx_q - CNT_ONE;
        if (rd_fire) begin
          rdata_q <= rd_masked;
          if (op_q[1]) acc_q <= acc_merged;
        end
      end
    end
  end

  assign cx_o            = cx_q;
  assign acc_o           = acc_q;
  assign mem_req_seg_o   = mem_req_we_o;
  assign mem_req_size_o  = size_q;
  assign mem_req_addr_o  = mem_req_we_o ? di_o : si_o;
  assign mem_req_wdata_o = (op_q == OP_MOVE) ? rdata_q : acc_masked;

endmodule

// File: rtl/strx_engine_chk.sv
module strx_engine_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [1:0]        op_i,
  input logic              rep_i,
  input logic [CNT_W-1:0]  cx_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [CNT_W-1:0]  cx_o,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic              mem_req_we_o,
  input logic [ADDR_W-1:0] mem_req_addr_o,
  input logic [DATA_W-1:0] mem_req_wdata_o
);
  logic [1:0]       op_l;
  logic             rep_l;
  logic             prev_busy;
  logic [CNT_W-1:0] prev_cx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_l      <= 2'd0;
      rep_l     <= 1'b0;
      prev_busy <= 1'b0;
      prev_cx   <= '0;
    end else begin
      if (start_i && !busy_o) begin
        op_l  <= op_i;
        rep_l <= rep_i;
      end
      prev_busy <= busy_o;
      prev_cx   <= cx_o;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o)
      && $stable(mem_req_we_o) && $stable(mem_req_wdata_o)); // R9
  AST_ZERO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o && rep_i && (cx_i == '0) |=> done_o && !mem_req_valid_o); // R4
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R11
  AST_SINGLE_CX: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && prev_busy && !rep_l |-> cx_o == prev_cx); // R5
  AST_LOAD_RONLY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && op_l[1] && mem_req_valid_o |-> !mem_req_we_o); // R6
  AST_STORE_WONLY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && (op_l == 2'd1) && mem_req_valid_o |-> mem_req_we_o); // R7

endmodule

bind strx_engine strx_engine_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start_i        (start_i),
  .op_i           (op_i),
  .rep_i          (rep_i),
  .cx_i           (cx_i),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .cx_o           (cx_o),
  .mem_req_valid_o(mem_req_valid_o),
  .mem_req_ready_i(mem_req_ready_i),
  .mem_req_we_o   (mem_req_we_o),
  .mem_req_addr_o (mem_req_addr_o),
  .mem_req_wdata_o(mem_req_wdata_o)
);

// File: tb/strx_engine_tb_top.sv
module strx_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [1:0]    op_i = 2'd0, size_i = 2'd0;
  logic          rep_i = 1'b0, dir_i = 1'b0;
  logic [AW-1:0] si_i = '0, di_i = '0;
  logic [CW-1:0] cx_i = '0;
  logic [DW-1:0] acc_i = '0;
  logic          busy_o, done_o;
  logic [AW-1:0] si_o, di_o;
  logic [CW-1:0] cx_o;
  logic [DW-1:0] acc_o;
  logic          mem_req_valid_o, mem_req_ready_i = 1'b0, mem_req_we_o, mem_req_seg_o;
  logic [1:0]    mem_req_size_o;
  logic [AW-1:0] mem_req_addr_o;
  logic [DW-1:0] mem_req_wdata_o;
  logic          mem_rsp_valid_i = 1'b0, mem_rsp_ready_o;
  logic [DW-1:0] mem_rsp_data_i = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strx_engine #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) dut_i (.*);

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0] mem0 [256];

  // Current operation as seen by the bench model
  logic [1:0]    cur_op, cur_size;
  logic          cur_dir;
  logic [DW-1:0] cur_acc;
  logic [AW-1:0] m_si, m_di;
  logic [DW-1:0] last_rd;
  int            rd_cnt, wr_cnt;
  bit            pend = 0;
  int            pend_dly;
  logic [DW-1:0] pend_data;
  bit            prev_stall = 0;
  logic [AW-1:0] prev_addr;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] a, input logic [1:0] sz, input logic d);
    return d ? a - AW'(nbytes(sz)) : a + AW'(nbytes(sz));
  endfunction

  function automatic logic [DW-1:0] lane_mask(input logic [1:0] sz);
    logic [DW-1:0] m = '0;
    for (int b = 0; b < nbytes(sz); b++) m[b*8 +: 8] = 8'hff;
    return m;
  endfunction

  function automatic logic [DW-1:0] rd_word(input logic [AW-1:0] a, input logic [1:0] sz);
    logic [DW-1:0] w = '0;
    for (int b = 0; b < nbytes(sz); b++) w[b*8 +: 8] = mem0[8'(a + AW'(b))];
    return w;
  endfunction

  // Monitor: requests and responses at the active edge
  always @(posedge clk) if (rst_n) begin
    if (prev_stall)
      chk(mem_req_valid_o && mem_req_addr_o == prev_addr, "R9 stalled request held",
          longint'(mem_req_addr_o), longint'(prev_addr));
    prev_stall = mem_req_valid_o && !mem_req_ready_i;
    prev_addr  = mem_req_addr_o;
    if (mem_rsp_valid_i && mem_rsp_ready_o) pend = 0;
    if (mem_req_valid_o && mem_req_ready_i) begin
      if (!mem_req_we_o) begin
        rd_cnt++;
        chk(mem_req_seg_o == 1'b0, "R1 read segment", longint'(mem_req_seg_o), 0);
        chk(mem_req_addr_o == m_si, "R1/R2 read address", longint'(mem_req_addr_o), longint'(m_si));
        pend_data = rd_word(mem_req_addr_o, cur_size);
        last_rd   = pend_data;
        pend      = 1;
        pend_dly  = int'($urandom % 3);
        m_si      = adv(m_si, cur_size, cur_dir);
      end else begin
        logic [DW-1:0] exp_wd;
        wr_cnt++;
        chk(mem_req_seg_o == 1'b1, "R1 write segment", longint'(mem_req_seg_o), 1);
        chk(mem_req_addr_o == m_di, "R1/R2 write address", longint'(mem_req_addr_o), longint'(m_di));
        if (cur_op == 2'd0) begin
          exp_wd = last_rd;
          chk(rd_cnt == wr_cnt, "R8 read precedes write", longint'(rd_cnt), longint'(wr_cnt));
        end else begin
          exp_wd = cur_acc & lane_mask(cur_size);
        end
        chk(mem_req_wdata_o == exp_wd, "R7/R8 write data", longint'(mem_req_wdata_o), longint'(exp_wd));
        m_di = adv(m_di, cur_size, cur_dir);
      end
    end
  end

  // Memory side driver, away from the active edge
  always @(negedge clk) begin
    mem_req_ready_i = ($urandom % 4) != 0;
    if (pend) begin
      if (pend_dly == 0) begin
        mem_rsp_valid_i = 1'b1;
        mem_rsp_data_i  = pend_data | ($urandom & ~lane_mask(cur_size));
      end else begin
        pend_dly--;
      end
    end else begin
      mem_rsp_valid_i = 1'b0;
    end
  end

  task automatic run_op(input logic [1:0] op, input logic [1:0] sz, input logic rep,
                        input logic d, input logic [AW-1:0] si, input logic [AW-1:0] di,
                        input logic [CW-1:0] cx, input logic [DW-1:0] acc, input bit poke);
    int n, k;
    logic [AW-1:0] e_si, e_di, la;
    logic [CW-1:0] e_cx;
    logic [DW-1:0] e_acc;
    logic [AW-1:0] s_si, s_di;
    logic [CW-1:0] s_cx;
    logic [DW-1:0] s_acc;
    cur_op = op; cur_size = sz; cur_dir = d; cur_acc = acc;
    m_si = si; m_di = di; rd_cnt = 0; wr_cnt = 0;
    n = rep ? int'(cx) : 1;
    e_si = si; e_di = di; la = si;
    for (int i = 0; i < n; i++) begin
      if (op != 2'd1) begin la = e_si; e_si = adv(e_si, sz, d); end
      if (op == 2'd0 || op == 2'd1) e_di = adv(e_di, sz, d);
    end
    e_cx  = rep ? '0 : cx;
    e_acc = acc;
    if (op[1] && n > 0) e_acc = (acc & ~lane_mask(sz)) | rd_word(la, sz);

    @(negedge clk);
    start_i = 1; op_i = op; size_i = sz; rep_i = rep; dir_i = d;
    si_i = si; di_i = di; cx_i = cx; acc_i = acc;
    @(negedge clk);
    start_i = 0;
    if (rep && cx == 0)
      chk(done_o == 1'b1, "R4 zero count done next cycle", longint'(done_o), 1);
    k = 0;
    while (!done_o && k < 3000) begin
      if (poke && k == 0) begin
        start_i = 1; si_i = ~si; di_i = ~di; cx_i = cx + 8'd3; dir_i = ~d; op_i = 2'd1;
      end else begin
        start_i = 0;
      end
      @(negedge clk);
      k++;
    end
    start_i = 0;
    chk(done_o == 1'b1, "R3 operation completes", longint'(done_o), 1);
    chk(si_o == e_si, rep ? "R3/R2 final source index" : "R5/R2 final source index",
        longint'(si_o), longint'(e_si));
    chk(di_o == e_di, op[1] ? "R6 destination untouched" : "R2 final destination index",
        longint'(di_o), longint'(e_di));
    chk(cx_o == e_cx, rep ? "R3 final count" : "R5 count unchanged", longint'(cx_o), longint'(e_cx));
    chk(acc_o == e_acc, op[1] ? "R6 loaded accumulator" : "R7/R8 accumulator kept",
        longint'(acc_o), longint'(e_acc));
    chk(rd_cnt == ((op != 2'd1) ? n : 0), "R6/R7/R8 read count", longint'(rd_cnt),
        longint'((op != 2'd1) ? n : 0));
    chk(wr_cnt == (op[1] ? 0 : n), "R6/R7/R8 write count", longint'(wr_cnt), longint'(op[1] ? 0 : n));
    if (poke)
      chk(si_o == e_si && cx_o == e_cx, "R10 start while busy ignored", longint'(si_o), longint'(e_si));
    s_si = si_o; s_di = di_o; s_cx = cx_o; s_acc = acc_o;
    @(negedge clk);
    chk(done_o == 1'b0, "R11 done is one cycle", longint'(done_o), 0);
    chk(si_o == s_si && di_o == s_di && cx_o == s_cx && acc_o == s_acc, "R11 results held",
        longint'(si_o), longint'(s_si));
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 256; i++) mem0[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0 && done_o == 1'b0 && mem_req_valid_o == 1'b0, "R11 reset idle",
        longint'({busy_o, done_o, mem_req_valid_o}), 0);
    rst_n = 1;
    @(negedge clk);
    // Directed corner cases
    run_op(2'd0, 2'd2, 1'b1, 1'b0, 8'h10, 8'h40, 8'd0, 32'h1122_3344, 1'b0);   // R4
    run_op(2'd1, 2'd0, 1'b0, 1'b0, 8'h20, 8'h30, 8'd5, 32'hA5A5_5A5A, 1'b0);   // R5
    run_op(2'd0, 2'd2, 1'b1, 1'b1, 8'h04, 8'hF8, 8'd4, 32'h0, 1'b0);           // R2 wrap down
    run_op(2'd0, 2'd1, 1'b1, 1'b0, 8'hFC, 8'h02, 8'd5, 32'h0, 1'b0);           // R2 wrap up
    run_op(2'd2, 2'd1, 1'b1, 1'b0, 8'h30, 8'h77, 8'd6, 32'hDEAD_BEEF, 1'b0);   // R6
    run_op(2'd1, 2'd2, 1'b1, 1'b1, 8'h55, 8'h80, 8'd3, 32'hCAFE_F00D, 1'b0);   // R7
    run_op(2'd0, 2'd0, 1'b1, 1'b0, 8'h00, 8'h90, 8'd7, 32'h0, 1'b1);           // R10
    run_op(2'd2, 2'd0, 1'b0, 1'b1, 8'h66, 8'h12, 8'd0, 32'h8765_4321, 1'b1);   // R5 + R10
    // Constrained random mix
    for (int t = 0; t < 40; t++) begin
      logic [1:0] op_r;
      op_r = 2'($urandom % 3);
      run_op(op_r, 2'($urandom % 3), 1'($urandom % 4 != 0), 1'($urandom),
             8'($urandom), 8'($urandom), 8'($urandom % 13), $urandom, 1'($urandom % 5 == 0));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule